// File: doc/BRIEF.md
# Power Mode Sequencer

This block moves a small controller between four power states: full run, idle (core halted, peripherals clocked), stop (oscillator off, everything frozen) and a warm-up state that follows stop. Software asks for idle or stop by writing request bits. The block acts on the request at the end of the current machine cycle, which is a fixed number of clock states. It drives the clock-gate enables for the oscillator, the CPU, the watchdog and the peripherals. It also drives a tri-state control for the output ports.

The two low-power states are left in different ways. Idle ends on any interrupt request. A one-cycle resume strobe then tells the core whether to take the interrupt or to continue with the next instruction, depending on the interrupt master enable. Stop ignores interrupts. Only a wake pin ends it, sensed either by level or by rising edge. The oscillator then runs alone for a selectable power-of-two warm-up time before the clocks are ungated and the core continues inline.

Top module: `stby_ctrl`

## Requirements
- R1: After reset the mode code is 0 (run), all four enables are 1, `port_hiz` is 0 and `resume_vld` is 0.
- R2: The mode code is 0 for run, 1 for idle, 2 for stop and 3 for warm-up. The machine cycle is 4 clocks and restarts at its first state after reset. Leaving run or idle happens only on the last clock of a machine cycle.
- R3: In idle, `osc_en` and `per_clk_en` are 1 and `cpu_clk_en` and `wdt_clk_en` are 0.
- R4: An `irq_req` that is high on the last clock of a machine cycle in idle returns the block to run. In the first run clock `resume_vld` is 1 for exactly one cycle, with `resume_vec` equal to `ime` as it was sampled at that edge.
- R5: In stop all four enables are 0. `port_hiz` equals `cfg_hiz` as captured at stop entry, and it holds through stop and warm-up. It is 0 in run and idle.
- R6: In stop, `irq_req` has no effect: the mode stays 2.
- R7: `wake_pin` passes through a 2-flop synchronizer. With `cfg_edge`=1, only a low-to-high change of the synchronized pin that is seen during stop ends stop. With `cfg_edge`=0, a high synchronized level ends stop.
- R8: Warm-up lasts 2^(2+`cfg_warm`) clocks. During it only `osc_en` is 1. It ends in run with `resume_vld`=1 and `resume_vec`=0.
- R9: With `cfg_edge`=0, a stop request that meets a high synchronized pin at its machine-cycle boundary is dropped. The mode stays run and the request does not come back.
- R10: A single write with `ctl_idle`=1 and `ctl_stop`=1 enters stop and discards the idle request.
- R11: A write (`ctl_we`=1) is ignored unless the mode is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control write strobe |
| ctl_idle | input | 1 | Idle request bit written with the strobe |
| ctl_stop | input | 1 | Stop request bit written with the strobe |
| cfg_hiz | input | 1 | Float the output ports during stop (1) or hold them (0) |
| cfg_edge | input | 1 | Wake pin sense: 1 rising edge, 0 high level |
| cfg_warm | input | 2 | Warm-up length select, 2^(2+value) clocks |
| irq_req | input | 1 | Any pending interrupt request |
| ime | input | 1 | Interrupt master enable |
| wake_pin | input | 1 | Asynchronous stop wake-up pin |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| port_hiz | output | 1 | Output ports in high impedance |
| resume_vld | output | 1 | One-cycle resume strobe |
| resume_vec | output | 1 | With the strobe: 1 take the interrupt, 0 continue inline |
| mode_code | output | 2 | Current power mode |

## Verification
The bench goes after the corners where the two wake paths differ. An interrupt pulsed during stop must not wake the block, and a design that shares the idle wake logic would leave stop early. An edge-sensed pin that is already high at stop entry must not wake the block, and a design that treats edge sense as level would wake at once. A level-sensed pin that is high at the request must drop the request. A design that does not clear the bit would fall into stop later, after the pin goes low. The bench also checks stop-over-idle priority, writes made while stopped, machine-cycle alignment, and the exact warm-up length for several selects. An off-by-one counter or a misplaced boundary shows up as a mode code that changes one cycle early or late.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_STOP = 2'd2,
      PM_WARM = 2'd3
   } pm_mode_e;
endpackage

// File: rtl/stby_mcycle.sv
// Machine-cycle state counter: runs while the core clock domain is live.
module stby_mcycle #(
   parameter int STATES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic last_o
);
   localparam int PH_W = (STATES > 2) ? $clog2(STATES) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(STATES - 1);

   initial assert (STATES >= 2) else $error("STATES must be at least 2");

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ph_q <= '0;
      else if (!run_i)      ph_q <= '0;
      else if (ph_q == PH_LAST) ph_q <= '0;
      else                  ph_q <= ph_q + 1'b1;
   end

   assign last_o = run_i && (ph_q == PH_LAST);

   AST_PH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !last_o);   // R2
endmodule

// File: rtl/stby_pin_sense.sv
// Wake pin synchronizer plus level / rising-edge detection.
module stby_pin_sense #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic edge_i,
   output logic level_o,
   output logic wake_o
);
   initial assert (SYNC >= 0 && SYNC <= 4) else $error("SYNC out of range");

   logic pin_s;
   logic pin_d;

   generate
      if (SYNC == 0) begin : g_nosync
         assign pin_s = pin_i;
      end else begin : g_sync
         logic [SYNC-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC-2 >= 0 ? SYNC-2 : 0 : 0], pin_i} & {SYNC{1'b1}};
         end
         assign pin_s = chain_q[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= 1'b0;
      else        pin_d <= pin_s;
   end

   assign level_o = pin_s;
   assign wake_o  = edge_i ? (pin_s && !pin_d) : pin_s;

   AST_EDGE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && wake_o) |=> !(edge_i && wake_o));   // R7
endmodule

// File: rtl/stby_warmup.sv
// Power-of-two warm-up down-counter.
module stby_warmup #(
   parameter int BASE  = 2,
   parameter int STEP  = 1,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             run_i,
   output logic             done_o
);
   localparam int MAX_EXP = BASE + STEP * ((1 << SEL_W) - 1);
   localparam int CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;

   initial assert (BASE >= 0 && STEP >= 0 && MAX_EXP <= 24)
      else $error("warm-up exponent out of range");

   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       shamt;
   logic [CNT_W-1:0] load_val;

   assign shamt    = 8'(BASE) + 8'(STEP) * 8'(sel_i);
   assign load_val = ({{(CNT_W-1){1'b0}}, 1'b1} << shamt) - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load_i)            cnt_q <= load_val;
      else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   AST_WARM_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));   // R8
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
   import stby_pkg::*;
#(
   parameter int MC_STATES = 4,
   parameter int PIN_SYNC  = 2,
   parameter int WARM_BASE = 2,
   parameter int WARM_STEP = 1,
   parameter int WARM_SELW = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic                 ctl_idle,
   input  logic                 ctl_stop,
   input  logic                 cfg_hiz,
   input  logic                 cfg_edge,
   input  logic [WARM_SELW-1:0] cfg_warm,
   input  logic                 irq_req,
   input  logic                 ime,
   input  logic                 wake_pin,
   output logic                 osc_en,
   output logic                 cpu_clk_en,
   output logic                 wdt_clk_en,
   output logic                 per_clk_en,
   output logic                 port_hiz,
   output logic                 resume_vld,
   output logic                 resume_vec,
   output logic [1:0]           mode_code
);
   pm_mode_e mode_q, mode_n;
   logic stop_pend, idle_pend;
   logic hiz_q;
   logic mc_last, core_live;
   logic pin_lvl, wake_hit;
   logic warm_done;
   logic boundary, skip_stop, take_stop, take_idle;
   logic idle_exit, warm_exit;

   assign core_live = (mode_q == PM_RUN) || (mode_q == PM_IDLE);

   stby_mcycle #(.STATES(MC_STATES)) u_mc (
      .clk(clk), .rst_n(rst_n), .run_i(core_live), .last_o(mc_last));

   stby_pin_sense #(.SYNC(PIN_SYNC)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin_i(wake_pin), .edge_i(cfg_edge),
      .level_o(pin_lvl), .wake_o(wake_hit));

   stby_warmup #(.BASE(WARM_BASE), .STEP(WARM_STEP), .SEL_W(WARM_SELW)) u_warm (
      .clk(clk), .rst_n(rst_n),
      .load_i((mode_q == PM_STOP) && wake_hit),
      .sel_i(cfg_warm), .run_i(mode_q == PM_WARM), .done_o(warm_done));

   assign boundary  = (mode_q == PM_RUN) && mc_last;
   assign skip_stop = boundary && stop_pend && !cfg_edge && pin_lvl;
   assign take_stop = boundary && stop_pend && !skip_stop;
   assign take_idle = boundary && !stop_pend && idle_pend;
   assign idle_exit = (mode_q == PM_IDLE) && mc_last && irq_req;
   assign warm_exit = (mode_q == PM_WARM) && warm_done;

   always_comb begin
      mode_n = mode_q;
      unique case (mode_q)
         PM_RUN:  if (take_stop) mode_n = PM_STOP;
                  else if (take_idle) mode_n = PM_IDLE;
         PM_IDLE: if (idle_exit) mode_n = PM_RUN;
         PM_STOP: if (wake_hit) mode_n = PM_WARM;
         PM_WARM: if (warm_done) mode_n = PM_RUN;
         default: mode_n = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= PM_RUN;
         stop_pend  <= 1'b0;
         idle_pend  <= 1'b0;
         hiz_q      <= 1'b0;
         resume_vld <= 1'b0;
         resume_vec <= 1'b0;
      end else begin
         mode_q     <= mode_n;
         resume_vld <= idle_exit || warm_exit;
         resume_vec <= idle_exit && ime;
         if (take_stop) hiz_q <= cfg_hiz;
         if ((mode_q == PM_RUN) && ctl_we) begin
            stop_pend <= ctl_stop;
            idle_pend <= ctl_idle && !ctl_stop;
         end else begin
            if (take_stop || skip_stop) stop_pend <= 1'b0;
            if (take_stop || take_idle) idle_pend <= 1'b0;
         end
      end
   end

   always_comb begin
      osc_en     = 1'b1;
      cpu_clk_en = 1'b0;
      wdt_clk_en = 1'b0;
      per_clk_en = 1'b0;
      unique case (mode_q)
         PM_RUN:  begin cpu_clk_en = 1'b1; wdt_clk_en = 1'b1; per_clk_en = 1'b1; end
         PM_IDLE: per_clk_en = 1'b1;
         PM_STOP: osc_en = 1'b0;
         default: ;
      endcase
   end

   assign port_hiz  = hiz_q && ((mode_q == PM_STOP) || (mode_q == PM_WARM));
   assign mode_code = mode_q;

   AST_CYCLE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (core_live && !mc_last) |=> (mode_q == $past(mode_q)));   // R2
   AST_IDLE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == PM_IDLE) && mc_last && irq_req) |=>
         (mode_q == PM_RUN && resume_vld && resume_vec == $past(ime)));   // R4
   AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resume_vld |=> !resume_vld);   // R4
   AST_HIZ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_STOP) |=> $stable(port_hiz));   // R5
   AST_STOP_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == PM_STOP) && !wake_hit) |=> (mode_q == PM_STOP));   // R6
   AST_WARM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == PM_WARM) && warm_done) |=>
         (mode_q == PM_RUN && resume_vld && !resume_vec));   // R8
   AST_LEVEL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && stop_pend && !cfg_edge && pin_lvl && !ctl_we) |=>
         (mode_q == PM_RUN && !stop_pend));   // R9
   AST_STOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == PM_RUN) && ctl_we && ctl_stop) |=> !idle_pend);   // R10
   AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q != PM_RUN) && ctl_we) |=> ($stable(stop_pend) && $stable(idle_pend)));   // R11
endmodule

// File: tb/tb_stby_ctrl.sv
module tb_stby_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_we = 0, ctl_idle = 0, ctl_stop = 0;
   logic cfg_hiz = 0, cfg_edge = 1;
   logic [1:0] cfg_warm = 2'd0;
   logic irq_req = 0, ime = 0, wake_pin = 0;
   logic osc_en, cpu_clk_en, wdt_clk_en, per_clk_en, port_hiz, resume_vld, resume_vec;
   logic [1:0] mode_code;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   logic got_rv = 0, got_rvec = 0;

   always #5 clk = ~clk;

   stby_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_idle(ctl_idle), .ctl_stop(ctl_stop),
      .cfg_hiz(cfg_hiz), .cfg_edge(cfg_edge), .cfg_warm(cfg_warm), .irq_req(irq_req),
      .ime(ime), .wake_pin(wake_pin), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
      .wdt_clk_en(wdt_clk_en), .per_clk_en(per_clk_en), .port_hiz(port_hiz),
      .resume_vld(resume_vld), .resume_vec(resume_vec), .mode_code(mode_code));

   // ---------------- behavioural reference model ----------------
   int m_mode, m_ph, m_cnt;
   bit m_sp, m_ip, m_hiz, m_rv, m_rvec;
   bit pin_q[$];      // synchronizer history, newest first
   bit m_prev;        // synchronized pin one cycle older

   function automatic bit m_pin();
      return pin_q[1];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_ph = 0; m_cnt = 0; m_sp = 0; m_ip = 0; m_hiz = 0;
         m_rv = 0; m_rvec = 0; pin_q = '{0, 0}; m_prev = 0;
      end else begin
         int nmode, nph;
         bit wk, spn, ipn;
         nmode = m_mode; spn = m_sp; ipn = m_ip;
         wk = cfg_edge ? (m_pin() && !m_prev) : m_pin();
         nph = (m_mode <= 1) ? (m_ph + 1) % 4 : 0;
         m_rv = 0; m_rvec = 0;
         case (m_mode)
            0: if (m_ph == 3) begin
                  if (m_sp) begin
                     spn = 0;
                     if (cfg_edge || !m_pin()) begin nmode = 2; ipn = 0; m_hiz = cfg_hiz; end
                  end else if (m_ip) begin
                     nmode = 1; ipn = 0;
                  end
               end
            1: if (m_ph == 3 && irq_req) begin nmode = 0; m_rv = 1; m_rvec = ime; end
            2: if (wk) begin nmode = 3; m_cnt = (1 << (2 + cfg_warm)) - 1; end
            default: if (m_cnt == 0) begin nmode = 0; m_rv = 1; end
                     else m_cnt = m_cnt - 1;
         endcase
         if (m_mode == 0 && ctl_we) begin spn = ctl_stop; ipn = ctl_idle && !ctl_stop; end
         m_prev = m_pin();
         pin_q.push_front(wake_pin);
         void'(pin_q.pop_back());
         m_mode = nmode; m_ph = nph; m_sp = spn; m_ip = ipn;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   function automatic string en_tag(int md);
      case (md)
         0: return "R1";
         1: return "R3";
         2: return "R5";
         default: return "R8";
      endcase
   endfunction

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk("R2 mode", mode_code, m_mode);
         chk({en_tag(m_mode), " osc"}, osc_en, m_mode != 2);
         chk({en_tag(m_mode), " cpu"}, cpu_clk_en, m_mode == 0);
         chk({en_tag(m_mode), " wdt"}, wdt_clk_en, m_mode == 0);
         chk({en_tag(m_mode), " per"}, per_clk_en, m_mode <= 1);
         chk("R5 hiz", port_hiz, m_hiz && m_mode >= 2);
         chk("R4 resume_vld", resume_vld, m_rv);
         chk("R4 resume_vec", resume_vec, m_rvec);
         if (resume_vld) begin got_rv = 1; got_rvec = resume_vec; end
      end
   end

   task automatic wr(bit idl, bit stp);
      @(negedge clk); ctl_we = 1; ctl_idle = idl; ctl_stop = stp;
      @(negedge clk); ctl_we = 0; ctl_idle = 0; ctl_stop = 0;
   endtask

   task automatic wait_mode(int tgt, string tag);
      for (int i = 0; i < 300; i++) begin
         if (mode_code == tgt) return;
         @(negedge clk);
      end
      chk({tag, " wait mode"}, mode_code, tgt);
   endtask

   task automatic idle_trip(bit en);
      ime = en; got_rv = 0;
      wr(1, 0);
      wait_mode(1, "R3");
      repeat (6) @(negedge clk);
      chk("R3 cpu gated in idle", cpu_clk_en, 0);
      chk("R3 per live in idle", per_clk_en, 1);
      irq_req = 1;
      wait_mode(0, "R4");
      @(negedge clk); irq_req = 0;
      chk("R4 resume strobe seen", got_rv, 1);
      chk("R4 resume vector follows ime", got_rvec, en);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mode", mode_code, 0);
      chk("R1 cpu", cpu_clk_en, 1);
      chk("R1 hiz", port_hiz, 0);
      chk("R1 resume", resume_vld, 0);
      repeat (5) @(negedge clk);

      idle_trip(1);
      idle_trip(0);

      // edge wake, hiz on, interrupts ignored in stop (R5, R6, R7, R8)
      cfg_edge = 1; cfg_hiz = 1; cfg_warm = 2'd1;
      wr(0, 1);
      wait_mode(2, "R5");
      chk("R5 osc off", osc_en, 0);
      chk("R5 hiz captured", port_hiz, 1);
      irq_req = 1; repeat (12) @(negedge clk); irq_req = 0;
      chk("R6 irq ignored in stop", mode_code, 2);
      got_rv = 0;
      wake_pin = 1;
      wait_mode(3, "R7");
      chk("R8 only osc in warm", {osc_en, cpu_clk_en, per_clk_en}, 3'b100);
      wait_mode(0, "R8");
      @(negedge clk);
      chk("R8 inline resume", got_rv && !got_rvec, 1);

      // edge sense: pin already high at entry must not wake (R7)
      cfg_hiz = 0;
      wr(0, 1);
      wait_mode(2, "R7");
      repeat (20) @(negedge clk);
      chk("R7 high pin without edge", mode_code, 2);
      chk("R5 hold policy", port_hiz, 0);
      wake_pin = 0; repeat (5) @(negedge clk); wake_pin = 1;
      wait_mode(0, "R7");

      // level sense, long warm-up (R7, R8)
      wake_pin = 0; cfg_edge = 0; cfg_warm = 2'd3;
      repeat (4) @(negedge clk);
      wr(0, 1);
      wait_mode(2, "R7");
      repeat (6) @(negedge clk);
      wake_pin = 1;
      wait_mode(3, "R7");
      wait_mode(0, "R8");
      wake_pin = 0; repeat (4) @(negedge clk);

      // level sense with pin high: request dropped (R9)
      wake_pin = 1; repeat (4) @(negedge clk);
      wr(0, 1);
      repeat (12) @(negedge clk);
      chk("R9 stop skipped", mode_code, 0);
      wake_pin = 0; repeat (12) @(negedge clk);
      chk("R9 request not retained", mode_code, 0);

      // both bits in one write: stop wins (R10); writes in stop ignored (R11)
      cfg_edge = 1; cfg_warm = 2'd0;
      wr(1, 1);
      wait_mode(2, "R10");
      chk("R10 stop over idle", mode_code, 2);
      wr(1, 0);
      wake_pin = 1;
      wait_mode(0, "R11");
      repeat (16) @(negedge clk);
      chk("R10 idle discarded / R11 write ignored", mode_code, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #200000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule